// File: doc/BRIEF.md
# Comma-Aligned Word Deserializer with Alternating Half-Rate Byte Clocks

This block turns a serial bit stream into 10-bit words that each carry one 8B/10B code group. It takes one bit on each rising edge of a recovered bit clock. It watches the stream through a 7-bit sliding window for a comma. When a comma arrives at a phase other than the current word boundary, the bit counter restarts so that the comma opens a new word. Any half-built word is dropped at that point.

Finished words appear on a registered 10-bit bus. The block also produces two byte clocks at one twentieth of the bit rate, always complementary to each other. Every byte clock transition happens five bit clocks after a word is registered. Successive words therefore sit centred on a rising edge of one byte clock and then the other. On a 1250 MBd line this gives two 62.5 MHz clocks against a 125 MHz word rate.

Top module: `comma_deser`

## Requirements
- R1: While `rst` is high at a rising `bit_clk` edge, `word_out` becomes 0, `comma_seen` and `locked` become 0, `byte_clk_a` becomes 0 and `byte_clk_b` becomes 1.
- R2: A comma is the seven most recent bits, including the one being sampled, equal in arrival order to 0011111 or to 1100000. No other 7-bit run counts as a comma.
- R3: Bits fill a word least significant first, so the first bit received lands in `word_out[0]` and the tenth lands in `word_out[9]`.
- R4: After a comma, its first bit becomes bit 0 of a new word. `word_out` takes that word on the same edge that samples its tenth bit.
- R5: When a comma restarts the boundary before the old boundary's word would have been completed, no partial word reaches `word_out`. It holds its previous value until the comma word is registered.
- R6: Between boundary restarts, a word is registered on every tenth `bit_clk` edge, and `word_out` holds it for the nine edges in between.
- R7: `comma_seen` is high for exactly one `bit_clk` cycle. That cycle is the one in which `word_out` first shows a word that holds a comma in bits 0 to 6.
- R8: `locked` stays low until the first comma word is registered. It goes high together with that `comma_seen` and stays high until reset. A stream with no comma leaves it low.
- R9: `byte_clk_b` is always the inverse of `byte_clk_a`. Both toggle on the fifth `bit_clk` edge after a word is registered, so that for aligned data the rising edge moves between the two clocks from one word to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Recovered bit clock, one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| word_out | output | 10 | Registered aligned word, first bit in bit 0 |
| comma_seen | output | 1 | One-cycle strobe with a word that holds a comma |
| locked | output | 1 | High once a comma has set the word boundary |
| byte_clk_a | output | 1 | Half-rate byte clock |
| byte_clk_b | output | 1 | Complement of `byte_clk_a` |

## Verification
The hardest case to reach from the pins is a comma that lands at a new phase after the block is already locked. There the partly built word has to disappear and the byte clock cadence has to restart. The bench locks the block onto a stream first. It then inserts every slip from one to nine bits, followed by a comma of either running disparity. For each slip it checks exactly when the comma word and its strobe appear. For the short slips, where the restart comes ahead of the old boundary, it also checks that `word_out` holds still throughout. Every initial phase from zero to nine junk bits is swept as well, together with both comma polarities.

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int W  = 10,
  parameter int KW = 7,
  parameter logic [KW-1:0] K_A = 7'b1111100,
  parameter logic [KW-1:0] K_B = 7'b0000011
) (
  input  logic         bit_clk,
  input  logic         rst,
  input  logic         ser_in,
  output logic [W-1:0] word_out,
  output logic         comma_seen,
  output logic         locked,
  output logic         byte_clk_a,
  output logic         byte_clk_b
);
  localparam int CNTW = $clog2(W);
  localparam logic [CNTW-1:0] LAST  = CNTW'(W - 1);
  localparam logic [CNTW-1:0] AFTER = CNTW'(KW);
  localparam logic [CNTW-1:0] MID   = CNTW'(W / 2 - 1);

  logic [W-1:0]    shreg, nxt;
  logic [CNTW-1:0] cnt;
  logic            hit, load, pend;

  assign nxt  = {ser_in, shreg[W-1:1]};
  assign hit  = (nxt[W-1 -: KW] == K_A) || (nxt[W-1 -: KW] == K_B);
  assign load = (cnt == LAST) && !hit;
  assign byte_clk_b = ~byte_clk_a;

  always_ff @(posedge bit_clk) begin
    if (rst) begin
      shreg      <= '0;
      cnt        <= '0;
      pend       <= 1'b0;
      word_out   <= '0;
      comma_seen <= 1'b0;
      locked     <= 1'b0;
      byte_clk_a <= 1'b0;
    end else begin
      shreg      <= nxt;
      cnt        <= hit ? AFTER : (cnt == LAST ? '0 : cnt + 1'b1);
      comma_seen <= load && pend;
      if (hit)       pend <= 1'b1;
      else if (load) pend <= 1'b0;
      if (load) begin
        word_out <= nxt;
        if (pend) locked <= 1'b1;
      end
      if (cnt == MID && !hit) byte_clk_a <= ~byte_clk_a;
    end
  end
endmodule

module comma_deser_chk #(
  parameter int W  = 10,
  parameter int KW = 7,
  parameter logic [KW-1:0] K_A = 7'b1111100,
  parameter logic [KW-1:0] K_B = 7'b0000011,
  parameter int CNTW = 4
) (
  input logic            bit_clk,
  input logic            rst,
  input logic [W-1:0]    word_out,
  input logic            comma_seen,
  input logic            locked,
  input logic            byte_clk_a,
  input logic            byte_clk_b,
  input logic [CNTW-1:0] cnt
);
  AST_WORD_HOLD: assert property (@(posedge bit_clk) disable iff (rst)
    (cnt != '0) |-> $stable(word_out));  // R6
  AST_STROBE_PULSE: assert property (@(posedge bit_clk) disable iff (rst)
    comma_seen |=> !comma_seen);  // R7
  AST_STROBE_CONTENT: assert property (@(posedge bit_clk) disable iff (rst)
    comma_seen |-> (word_out[KW-1:0] == K_A || word_out[KW-1:0] == K_B));  // R2
  AST_STROBE_BOUNDARY: assert property (@(posedge bit_clk) disable iff (rst)
    comma_seen |-> (cnt == '0));  // R4
  AST_LOCK_STICKY: assert property (@(posedge bit_clk) disable iff (rst)
    locked |=> locked);  // R8
  AST_LOCK_WITH_COMMA: assert property (@(posedge bit_clk) disable iff (rst)
    comma_seen |-> locked);  // R8
  AST_CLK_PHASE: assert property (@(posedge bit_clk) disable iff (rst)
    !$stable(byte_clk_a) |-> (cnt == CNTW'(W / 2)));  // R9
  AST_CLK_COMPL: assert property (@(posedge bit_clk) disable iff (rst)
    byte_clk_a != byte_clk_b);  // R9
endmodule

bind comma_deser comma_deser_chk #(.W(W), .KW(KW), .K_A(K_A), .K_B(K_B), .CNTW(CNTW)) chk_i (
  .bit_clk(bit_clk), .rst(rst), .word_out(word_out), .comma_seen(comma_seen),
  .locked(locked), .byte_clk_a(byte_clk_a), .byte_clk_b(byte_clk_b), .cnt(cnt)
);

// File: tb/comma_deser_tb_top.sv
module comma_deser_tb_top;
  logic       bit_clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b0;
  logic [9:0] word_out;
  logic       comma_seen, locked, byte_clk_a, byte_clk_b;
  int         tests = 0;
  int         fails = 0;

  localparam logic [9:0] KNEG = 10'b0101111100; // arrival 0011111010
  localparam logic [9:0] KPOS = 10'b1010000011; // arrival 1100000101
  localparam logic [9:0] DW0  = 10'b0101010101;
  localparam logic [9:0] DW1  = 10'b1001100110;
  localparam logic [9:0] DW2  = 10'b0110011001;

  always #10 bit_clk = ~bit_clk;

  comma_deser dut_i (
    .bit_clk(bit_clk), .rst(rst), .ser_in(ser_in), .word_out(word_out),
    .comma_seen(comma_seen), .locked(locked),
    .byte_clk_a(byte_clk_a), .byte_clk_b(byte_clk_b)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic bit_in(input logic b);
    @(negedge bit_clk);
    ser_in = b;
    @(posedge bit_clk);
    #5;
  endtask

  function automatic logic [9:0] dword(input int k);
    case (k % 3)
      0: return DW0;
      1: return DW1;
      default: return DW2;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge bit_clk);
    rst = 1'b1;
    @(posedge bit_clk);
    @(posedge bit_clk);
    #5;
    chk("R1 word_out", word_out, 10'd0);
    chk("R1 comma_seen", {9'd0, comma_seen}, 10'd0);
    chk("R1 locked", {9'd0, locked}, 10'd0);
    chk("R1 byte_clk_a", {9'd0, byte_clk_a}, 10'd0);
    chk("R1 byte_clk_b", {9'd0, byte_clk_b}, 10'd1);
    @(negedge bit_clk);
    rst = 1'b0;
  endtask

  // comma word; when hold is set, word_out must keep prev until the last bit
  task automatic send_comma(input logic [9:0] cw, input bit hold, input logic [9:0] prev,
                            output logic ca);
    for (int i = 0; i < 10; i++) begin
      bit_in(cw[i]);
      if (i < 9) begin
        chk("R7 no early strobe", {9'd0, comma_seen}, 10'd0);
        if (hold) chk("R5 partial dropped", word_out, prev);
      end else begin
        chk("R4 R3 comma word", word_out, cw);
        chk("R7 strobe", {9'd0, comma_seen}, 10'd1);
        chk("R8 locked", {9'd0, locked}, 10'd1);
      end
    end
    ca = byte_clk_a;
  endtask

  task automatic send_data(input logic [9:0] dw, input logic [9:0] prev, inout logic ca);
    for (int i = 0; i < 10; i++) begin
      bit_in(dw[i]);
      if (i == 0) chk("R7 one cycle", {9'd0, comma_seen}, 10'd0);
      if (i < 9) chk("R6 hold", word_out, prev);
      else chk("R6 R3 data word", word_out, dw);
      if (i < 4) chk("R9 clk steady", {9'd0, byte_clk_a}, {9'd0, ca});
      if (i == 4) begin
        chk("R9 clk toggles", {9'd0, byte_clk_a}, {9'd0, ~ca});
        chk("R9 complement", {9'd0, byte_clk_b}, {9'd0, ca});
        ca = byte_clk_a;
      end
    end
    chk("R8 stays locked", {9'd0, locked}, 10'd1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic       ca;
    logic [9:0] cw, prev;
    for (int pol = 0; pol < 2; pol++) begin
      for (int p = 0; p < 10; p++) begin
        cw = pol ? KPOS : KNEG;
        do_reset();
        for (int j = 0; j < 10 + p; j++) bit_in(j[0]);
        chk("R8 no comma no lock", {9'd0, locked}, 10'd0);
        chk("R2 no false comma", {9'd0, comma_seen}, 10'd0);
        send_comma(cw, 1'b0, 10'd0, ca);
        prev = cw;
        for (int k = 0; k < 3; k++) begin
          send_data(dword(k + p), prev, ca);
          prev = dword(k + p);
        end
        for (int s = 0; s < (p % 9) + 1; s++) begin
          bit_in(s[0]);
          if ((p % 9) + 1 <= 3) chk("R5 slip hold", word_out, prev);
        end
        send_comma(pol ? KNEG : KPOS, ((p % 9) + 1) <= 3, prev, ca);
        send_data(dword(p), pol ? KNEG : KPOS, ca);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule